// File: doc/BRIEF.md
# Bit-Plane Serial Matrix-Vector Multiplier

This block holds a matrix of small signed weights and, on request, multiplies it by an input vector of unsigned integers. It does not use a multiplier array. The input vector is split into bit planes, and the weight matrix is split into bit planes. For each pair of planes, every row takes a binary inner product: it counts the columns where a weight bit and an input bit are both one. Each count is shifted by the sum of the two plane indices and added into a per-row accumulator. Each weight bit is a pair of cells, one positive and one negative, so the same datapath handles signed weights.

A run visits one pair of planes per cycle. The input plane index is the outer loop and the weight plane index is the inner loop. Optional dither adds a pseudo-random offset vector U to X before the planes are formed. U comes from a free-running LFSR and is captured when the run starts. The same U planes drive a second accumulator that forms W·U, and that term is subtracted at the output, so the result is W·X exactly. Software-side logic loads weights one cell at a time through an addressed write port while the block is idle, then pulses a start input and waits for a done strobe.

Top module: `bit_plane_mvm`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every row of `y` reads 0.
- R2: With all negative cells 0, each row result equals the sum over columns of weight × input. The input for column c is `x_vec[c*XBITS +: XBITS]` (unsigned). The weight for row r, column c is the value last written to `wr_pos` at that address. Row r appears at `y[r*YW +: YW]` in two's complement.
- R3: A weight's value is P − N, where P is its positive-cell word and N its negative-cell word. In each plane, a pos/neg pair of 1/0 adds +2^i, a pair of 0/1 adds −2^i, and equal cells add nothing.
- R4: A start seen while idle sets `busy` in the next cycle. `done` rises exactly (XBITS+1)·WBITS cycles after the accepted start edge, lasts one cycle, and coincides with `busy` falling.
- R5: With `dither_en` high at start, the result equals the result without dither for the same W and X, whatever the LFSR state.
- R6: A start pulse during a run is ignored: the latency and the result stay those of the first run.
- R7: A weight write while `busy` is high is dropped. A write while idle takes effect in the next run.
- R8: Between `done` and the next accepted start, `y` holds its value whatever `x_vec` and `dither_en` do.
- R9: Full-scale inputs with full-scale positive or full-scale negative weights give exact results without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Weight cell write strobe, honoured only when idle |
| wr_row | input | RW | Row address of the write |
| wr_col | input | CW | Column address of the write |
| wr_pos | input | WBITS | Positive cells, bit i for weight plane i |
| wr_neg | input | WBITS | Negative cells, bit i for weight plane i |
| start | input | 1 | Run request, honoured only when idle |
| dither_en | input | 1 | Add LFSR offset to the inputs for this run |
| x_vec | input | COLS*XBITS | Input vector, column c at [c*XBITS +: XBITS] |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle strobe after the last plane pair |
| y | output | ROWS*YW | Signed row results, row r at [r*YW +: YW] |

## Verification
The bench first uses a saturated pattern: every input at full scale and every weight at full scale. This separates correct carry and shift weighting from truncation, in both polarities. Randomised unsigned matrices are then compared against signed matrices that include cells with both halves set, which shows whether the negative cell is subtracted or ignored. Each matrix is run twice, once plain and once dithered, so a residual from an inexact W·U cancellation cannot hide. Start pulses and weight writes are injected in the middle of a run; these show that the operand and weight latches are guarded and that the run length is fixed.

// File: rtl/bpmvm_pkg.sv
package bpmvm_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // x^16 + x^14 + x^13 + x^11 + 1, Fibonacci form
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int ubits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bpmvm_seq.sv
module bpmvm_seq
  import bpmvm_pkg::*;
#(
  parameter int WBITS = 3,
  parameter int XP    = 4,
  localparam int WI_W = ubits(WBITS),
  localparam int XJ_W = ubits(XP),
  localparam int SH_W = ubits(WBITS + XP - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic [WI_W-1:0]   wsel,
  output logic [XJ_W-1:0]   xsel,
  output logic [SH_W-1:0]   shift,
  output logic [LFSR_W-1:0] lfsr
);
  logic            busy_q, busy_d, done_q, done_d, last, wwrap;
  logic [WI_W-1:0] wi_q, wi_d;
  logic [XJ_W-1:0] xj_q, xj_d;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    accept = start && !busy_q;
    wwrap  = (wi_q == WI_W'(WBITS - 1));
    last   = busy_q && wwrap && (xj_q == XJ_W'(XP - 1));
    busy_d = busy_q;
    wi_d   = wi_q;
    xj_d   = xj_q;
    if (accept) begin
      busy_d = 1'b1;
      wi_d   = '0;
      xj_d   = '0;
    end else if (busy_q) begin
      wi_d = wwrap ? '0 : wi_q + 1'b1;
      if (wwrap) xj_d = xj_q + 1'b1;
      if (last)  busy_d = 1'b0;
    end
    done_d = last;
    lfsr_d = lfsr_step(lfsr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wi_q   <= '0;
      xj_q   <= '0;
      lfsr_q <= LFSR_SEED;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      wi_q   <= wi_d;
      xj_q   <= xj_d;
      lfsr_q <= lfsr_d;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign wsel  = wi_q;
  assign xsel  = xj_q;
  assign shift = SH_W'(wi_q) + SH_W'(xj_q);
  assign lfsr  = lfsr_q;

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_ends_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last) |=> (busy_q && !done_q));
endmodule

// File: rtl/bpmvm_wstore.sv
module bpmvm_wstore
  import bpmvm_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int WBITS = 3,
  localparam int RW   = ubits(ROWS),
  localparam int CW   = ubits(COLS),
  localparam int WI_W = ubits(WBITS),
  localparam int NB   = ROWS * COLS * WBITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_row,
  input  logic [CW-1:0]        wr_col,
  input  logic [WBITS-1:0]     wr_pos,
  input  logic [WBITS-1:0]     wr_neg,
  input  logic [WI_W-1:0]      wsel,
  output logic [ROWS*COLS-1:0] pos_sel,
  output logic [ROWS*COLS-1:0] neg_sel
);
  logic [NB-1:0] pos_q, pos_d, neg_q, neg_d;

  always_comb begin
    pos_d = pos_q;
    neg_d = neg_q;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (wr_en && !busy && wr_row == RW'(r) && wr_col == CW'(c)) begin
          pos_d[(r*COLS + c)*WBITS +: WBITS] = wr_pos;
          neg_d[(r*COLS + c)*WBITS +: WBITS] = wr_neg;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      neg_q <= '0;
    end else begin
      pos_q <= pos_d;
      neg_q <= neg_d;
    end
  end

  for (genvar g = 0; g < ROWS*COLS; g++) begin : g_cell
    logic [WBITS-1:0] pc, nc;
    assign pc = pos_q[g*WBITS +: WBITS];
    assign nc = neg_q[g*WBITS +: WBITS];
    assign pos_sel[g] = pc[wsel];
    assign neg_sel[g] = nc[wsel];
  end

  assert_write_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> ($stable(pos_q) && $stable(neg_q)));
endmodule

// File: rtl/bpmvm_row_mac.sv
module bpmvm_row_mac #(
  parameter int COLS = 8,
  parameter int YW   = 12,
  parameter int SH_W = 3,
  localparam int CNT_W = $clog2(COLS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [SH_W-1:0]      sh,
  input  logic [COLS-1:0]      pos_row,
  input  logic [COLS-1:0]      neg_row,
  input  logic [COLS-1:0]      xpl,
  input  logic [COLS-1:0]      upl,
  output logic signed [YW-1:0] y_row
);
  logic signed [YW-1:0] acc_q, acc_d, accu_q, accu_d, tx, tu;

  // signed, shifted inner product of one weight plane with one input plane
  function automatic logic signed [YW-1:0] plane_term(
    input logic [COLS-1:0] p, input logic [COLS-1:0] n,
    input logic [COLS-1:0] b, input logic [SH_W-1:0] s);
    logic [CNT_W-1:0] cp, cn;
    logic [CNT_W:0]   d;
    logic [YW-1:0]    ext;
    cp  = CNT_W'($countones(p & b));
    cn  = CNT_W'($countones(n & b));
    d   = {1'b0, cp} - {1'b0, cn};
    ext = {{(YW-CNT_W-1){d[CNT_W]}}, d};
    return $signed(ext << s);
  endfunction

  always_comb begin
    tx     = plane_term(pos_row, neg_row, xpl, sh);
    tu     = plane_term(pos_row, neg_row, upl, sh);
    acc_d  = acc_q;
    accu_d = accu_q;
    if (clr) begin
      acc_d  = '0;
      accu_d = '0;
    end else if (en) begin
      acc_d  = acc_q + tx;
      accu_d = accu_q + tu;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      accu_q <= '0;
    end else begin
      acc_q  <= acc_d;
      accu_q <= accu_d;
    end
  end

  assign y_row = acc_q - accu_q;
endmodule

// File: rtl/bit_plane_mvm.sv
module bit_plane_mvm
  import bpmvm_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int WBITS = 3,
  parameter int XBITS = 3,
  localparam int RW    = ubits(ROWS),
  localparam int CW    = ubits(COLS),
  localparam int XP    = XBITS + 1,
  localparam int WI_W  = ubits(WBITS),
  localparam int XJ_W  = ubits(XP),
  localparam int SH_W  = ubits(WBITS + XP - 1),
  localparam int YW    = $clog2(COLS + 1) + WBITS + XP + 1,
  localparam int USPAN = LFSR_W - XBITS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_row,
  input  logic [CW-1:0]        wr_col,
  input  logic [WBITS-1:0]     wr_pos,
  input  logic [WBITS-1:0]     wr_neg,
  input  logic                 start,
  input  logic                 dither_en,
  input  logic [COLS*XBITS-1:0] x_vec,
  output logic                 busy,
  output logic                 done,
  output logic [ROWS*YW-1:0]   y
);
  logic                 accept;
  logic [WI_W-1:0]      wsel;
  logic [XJ_W-1:0]      xsel;
  logic [SH_W-1:0]      shift;
  logic [LFSR_W-1:0]    lfsr;
  logic [ROWS*COLS-1:0] pos_sel, neg_sel;
  logic [COLS*XP-1:0]   xd_q, xd_d, ud_q, ud_d;
  logic [COLS-1:0]      xpl, upl;

  bpmvm_seq #(.WBITS(WBITS), .XP(XP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .busy(busy), .done(done), .wsel(wsel), .xsel(xsel),
    .shift(shift), .lfsr(lfsr));

  bpmvm_wstore #(.ROWS(ROWS), .COLS(COLS), .WBITS(WBITS)) u_wstore (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en),
    .wr_row(wr_row), .wr_col(wr_col), .wr_pos(wr_pos), .wr_neg(wr_neg),
    .wsel(wsel), .pos_sel(pos_sel), .neg_sel(neg_sel));

  // operand capture: X+U and U, each one bit wider than the input
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int UOFF = (c * 5) % USPAN;
    logic [XBITS-1:0] xin, uin;
    logic [XP-1:0]    xcell, ucell;
    assign xin   = x_vec[c*XBITS +: XBITS];
    assign uin   = dither_en ? lfsr[UOFF +: XBITS] : '0;
    assign xd_d[c*XP +: XP] = accept ? ({1'b0, xin} + {1'b0, uin}) : xd_q[c*XP +: XP];
    assign ud_d[c*XP +: XP] = accept ? {1'b0, uin} : ud_q[c*XP +: XP];
    assign xcell = xd_q[c*XP +: XP];
    assign ucell = ud_q[c*XP +: XP];
    assign xpl[c] = xcell[xsel];
    assign upl[c] = ucell[xsel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xd_q <= '0;
      ud_q <= '0;
    end else begin
      xd_q <= xd_d;
      ud_q <= ud_d;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic signed [YW-1:0] yr;
    bpmvm_row_mac #(.COLS(COLS), .YW(YW), .SH_W(SH_W)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(accept), .en(busy), .sh(shift),
      .pos_row(pos_sel[r*COLS +: COLS]), .neg_row(neg_sel[r*COLS +: COLS]),
      .xpl(xpl), .upl(upl), .y_row(yr));
    assign y[r*YW +: YW] = yr;
  end

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(y));
endmodule

// File: tb/bit_plane_mvm_tb.sv
`timescale 1ns/1ps
module bit_plane_mvm_tb;
  localparam int ROWS = 4, COLS = 8, WBITS = 3, XBITS = 3;
  localparam int RW = 2, CW = 3, XP = XBITS + 1;
  localparam int YW = $clog2(COLS + 1) + WBITS + XP + 1;
  localparam int NPAIR = XP * WBITS;
  localparam int WMAX = (1 << WBITS) - 1, XMAX = (1 << XBITS) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, dither_en = 1'b0;
  logic [RW-1:0] wr_row = '0;
  logic [CW-1:0] wr_col = '0;
  logic [WBITS-1:0] wr_pos = '0, wr_neg = '0;
  logic [COLS*XBITS-1:0] x_vec = '0;
  logic busy, done;
  logic [ROWS*YW-1:0] y;

  int checks = 0, errors = 0;
  int wp[ROWS][COLS], wn[ROWS][COLS], xv[COLS];
  int unsigned seed = 32'd12345;

  always #2.5 clk = ~clk;

  bit_plane_mvm #(.ROWS(ROWS), .COLS(COLS), .WBITS(WBITS), .XBITS(XBITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_pos(wr_pos), .wr_neg(wr_neg), .start(start), .dither_en(dither_en),
    .x_vec(x_vec), .busy(busy), .done(done), .y(y));

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % m);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_row(input int r);
    int s = 0;
    for (int c = 0; c < COLS; c++) s += (wp[r][c] - wn[r][c]) * xv[c];
    return s;
  endfunction

  function automatic int yrow(input int r);
    return int'($signed(y[r*YW +: YW]));
  endfunction

  task automatic check_rows(input string req);
    for (int r = 0; r < ROWS; r++) chk(req, yrow(r), expect_row(r));
  endtask

  task automatic wr(input int r, input int c, input int p, input int n);
    wr_en = 1'b1; wr_row = RW'(r); wr_col = CW'(c);
    wr_pos = WBITS'(p); wr_neg = WBITS'(n);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) wr(r, c, wp[r][c], wn[r][c]);
  endtask

  task automatic apply_x();
    for (int c = 0; c < COLS; c++) x_vec[c*XBITS +: XBITS] = XBITS'(xv[c]);
  endtask

  // mode 0 plain, 1 start pulse mid-run, 2 weight write mid-run
  task automatic run(input bit dith, input int mode);
    int lat = 0;
    apply_x();
    dither_en = dith; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dither_en = 1'b0;
    chk("R4 busy after start", int'(busy), 1);
    while (1) begin
      if (mode == 1 && lat == 4) begin start = 1'b1; x_vec = ~x_vec; dither_en = 1'b1; end
      if (mode == 2 && lat == 4) begin
        wr_en = 1'b1; wr_row = '0; wr_col = '0; wr_pos = 3'b101; wr_neg = 3'b010;
      end
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0; dither_en = 1'b0;
      lat++;
      if (done || lat > 1000) break;
    end
    chk(mode == 1 ? "R6 latency" : "R4 latency", lat, NPAIR);
    chk("R4 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk("R4 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    for (int r = 0; r < ROWS; r++) chk("R1 y zero", yrow(r), 0);

    // R9 full scale, positive then negative, plain and dithered
    for (int pol = 0; pol < 2; pol++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          wp[r][c] = pol ? 0 : WMAX; wn[r][c] = pol ? WMAX : 0;
        end
      for (int c = 0; c < COLS; c++) xv[c] = XMAX;
      load_all();
      run(1'b0, 0); check_rows("R9 full scale");
      run(1'b1, 0); check_rows("R9 full scale dithered");
    end

    // R2 unsigned sweep; R5 dither must not change result
    for (int t = 0; t < 12; t++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          wp[r][c] = (t == 0) ? ((c == r) ? 1 : 0) : rnd(WMAX + 1); wn[r][c] = 0;
        end
      for (int c = 0; c < COLS; c++) xv[c] = (t == 1) ? ((c == t) ? XMAX : 0) : rnd(XMAX + 1);
      load_all();
      run(1'b0, 0); check_rows("R2 unsigned");
      run(1'b1, 0); check_rows("R5 dithered unsigned");
    end

    // R3 signed cell pairs, including cells with both halves set
    for (int t = 0; t < 12; t++) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          wp[r][c] = rnd(WMAX + 1); wn[r][c] = (t == 0) ? wp[r][c] : rnd(WMAX + 1);
        end
      for (int c = 0; c < COLS; c++) xv[c] = rnd(XMAX + 1);
      load_all();
      run(1'b0, 0); check_rows("R3 signed");
      run(1'b1, 0); check_rows("R5 dithered signed");
    end

    // R6 start during a run is ignored
    run(1'b0, 1); check_rows("R6 mid-run start");

    // R7 write during a run is dropped, write while idle applies
    run(1'b0, 2); check_rows("R7 mid-run write");
    run(1'b0, 0); check_rows("R7 weights kept");
    wp[0][0] = 5; wn[0][0] = 2;
    wr(0, 0, 5, 2);
    run(1'b0, 0); check_rows("R7 idle write");

    // R8 result holds while idle with moving inputs
    for (int k = 0; k < 8; k++) begin
      x_vec = ~x_vec; dither_en = k[0];
      @(negedge clk);
    end
    dither_en = 1'b0;
    check_rows("R8 hold");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule